// File: doc/BRIEF.md
# Mini UART Register Front-End

This block is the register side of a stripped-down auxiliary serial port. A host reaches it through a 32-bit bus that does one word-wide access per cycle. Bytes coming in from the line side are offered on a valid/ready byte input and kept in a circular receive queue. The host drains the queue by reading the data register. Writing the data register sends the low byte out on a one-cycle transmit strobe. There is no shift register behind that strobe, so the transmitter always reports idle and empty, and its interrupt is pending whenever it is enabled.

The receive queue is tracked by a small occupancy state machine with three states: `FQ_EMPTY`, `FQ_PARTIAL` and `FQ_FULL`. Its transitions are:

- **fill**: `FQ_EMPTY` to `FQ_PARTIAL`, when a byte is accepted.
- **drain**: `FQ_PARTIAL` to `FQ_EMPTY`, when the last byte is read out.
- **top-up**: `FQ_PARTIAL` to `FQ_FULL`, when the last free slot is written.
- **release**: `FQ_FULL` to `FQ_PARTIAL`, when a byte is read.
- **flush**: any state to `FQ_EMPTY`, when the identification register is written with bit 1 set.

The interrupt line, the identification code, the line status and the extended status are all derived from the queue count and the two stored enable bits.

Read data is combinational from the state held at the start of the access cycle. Every state change, including the pop caused by a data read, takes effect at the clock edge that ends the cycle.

Top module: `mu_regfront`

## Requirements
- R1: After reset the queue is empty, both enable bits are 0, every queue slot holds 0, `irq` and `tx_valid` are low, and `rx_ready` is high.
- R2: Offset 0x04 reads 1 and offset 0x60 reads 3. Any offset other than 0x00, 0x04, 0x40, 0x44, 0x48, 0x54, 0x60 and 0x64 reads 0, and a write to it changes no state.
- R3: A write to offset 0x44 stores write-data bit 0 (receive enable) and bit 1 (transmit enable) and nothing else. A read of 0x44 returns 0xC0 ORed with those two bits.
- R4: `irq` is high exactly when the transmit enable is set, or the receive enable is set and the queue is non-empty. Offset 0x00 reads 1 in that case and 0 otherwise.
- R5: A read of offset 0x48 returns 0xC0, ORed with 0x4 if the queue is non-empty or with 0x2 if it is empty, and ORed with 0x1 when `irq` is low.
- R6: A write to offset 0x48 with bit 1 set sets the count to 0 at the end of that cycle. `rx_ready` is low during that cycle. A write with bit 1 clear has no effect.
- R7: A read of offset 0x40 while the queue is non-empty returns the oldest byte, then advances the read slot modulo the depth and lowers the count by one. Bytes come out in arrival order across the wrap.
- R8: A read of offset 0x40 while the queue is empty returns the byte held in the slot at the read position and leaves the count and read position unchanged.
- R9: Offset 0x54 reads 0x60, with bit 0 set when the queue is non-empty.
- R10: Offset 0x64 reads 0x30E when the queue is empty. Otherwise it reads 0x30F ORed with the count shifted left by 16.
- R11: `rx_ready` is high when the count is below the depth (8) and no flush write is in progress. An accepted byte is stored in slot (read position + count) mod depth. When the queue is full, offered bytes are dropped and the count stays at the depth.
- R12: A write to offset 0x40 makes `tx_valid` high for exactly the next cycle, with `tx_data` equal to write-data bits 7:0. `tx_valid` is low in every other cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| bus_sel | input | 1 | Register access in this cycle |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | 8 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid in the access cycle |
| rx_valid | input | 1 | A received byte is offered |
| rx_data | input | 8 | Offered received byte |
| rx_ready | output | 1 | The offered byte is taken at this edge |
| tx_valid | output | 1 | One-cycle transmit strobe |
| tx_data | output | 8 | Byte being transmitted |
| irq | output | 1 | Interrupt request |

## Verification
Read data and `rx_ready` are due in the access cycle itself, because they come straight from the state held before the edge. The effect of a push, a pop, a flush or an enable write on `irq`, the count and every later read appears one edge later. `tx_valid` and `tx_data` are due exactly one edge after the data-register write. The bench drives each cycle's inputs at the falling edge and compares against its queue model 1 ns later. It advances the model once per rising edge, so every comparison uses the model state that the last edge produced.

// File: rtl/mu_pkg.sv
package mu_pkg;
    localparam int BYTE_W = 8;

    localparam logic [7:0] OFS_IRQFLAG = 8'h00;
    localparam logic [7:0] OFS_ENABLES = 8'h04;
    localparam logic [7:0] OFS_DATA    = 8'h40;
    localparam logic [7:0] OFS_IEN     = 8'h44;
    localparam logic [7:0] OFS_IID     = 8'h48;
    localparam logic [7:0] OFS_LSTAT   = 8'h54;
    localparam logic [7:0] OFS_CTRL    = 8'h60;
    localparam logic [7:0] OFS_XSTAT   = 8'h64;

    typedef enum logic [1:0] {
        FQ_EMPTY   = 2'd0,
        FQ_PARTIAL = 2'd1,
        FQ_FULL    = 2'd2
    } fq_state_t;
endpackage

// File: rtl/mu_rx_fifo.sv
module mu_rx_fifo
    import mu_pkg::*;
#(
    parameter int DEPTH = 8,
    parameter int CNT_W = $clog2(DEPTH + 1),
    parameter int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [BYTE_W-1:0] push_data,
    input  logic              pop_req,
    input  logic              flush,
    output logic [BYTE_W-1:0] head_data,
    output logic [CNT_W-1:0]  fill,
    output logic              nonempty,
    output logic              full
);
    localparam logic [CNT_W-1:0] DEPTH_C  = CNT_W'(DEPTH);
    localparam logic [CNT_W:0]   DEPTH_X  = (CNT_W + 1)'(DEPTH);
    localparam logic [PTR_W-1:0] LAST_PTR = PTR_W'(DEPTH - 1);

    fq_state_t         state_q, state_d;
    logic [CNT_W-1:0]  fill_q, fill_d;
    logic [PTR_W-1:0]  rd_ptr_q;
    logic [PTR_W-1:0]  wr_slot;
    logic [CNT_W:0]    slot_sum;
    logic              pop;
    logic [BYTE_W-1:0] mem [DEPTH];

    // occupancy flags decoded from the state
    always_comb begin
        nonempty = 1'b0;
        full     = 1'b0;
        unique case (state_q)
            FQ_EMPTY:   begin nonempty = 1'b0; full = 1'b0; end
            FQ_PARTIAL: begin nonempty = 1'b1; full = 1'b0; end
            FQ_FULL:    begin nonempty = 1'b1; full = 1'b1; end
            default:    begin nonempty = 1'b0; full = 1'b0; end
        endcase
    end

    assign pop = pop_req && nonempty;

    always_comb begin
        if (flush)
            fill_d = '0;
        else if (push && !pop)
            fill_d = fill_q + 1'b1;
        else if (pop && !push)
            fill_d = fill_q - 1'b1;
        else
            fill_d = fill_q;
    end

    // transitions: fill, drain, top-up, release, flush
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            FQ_EMPTY: begin
                if (!flush && push)
                    state_d = (fill_d == DEPTH_C) ? FQ_FULL : FQ_PARTIAL;
            end
            FQ_PARTIAL: begin
                if (fill_d == '0)
                    state_d = FQ_EMPTY;
                else if (fill_d == DEPTH_C)
                    state_d = FQ_FULL;
            end
            FQ_FULL: begin
                if (fill_d == '0)
                    state_d = FQ_EMPTY;
                else if (fill_d != DEPTH_C)
                    state_d = FQ_PARTIAL;
            end
            default: state_d = FQ_EMPTY;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q  <= FQ_EMPTY;
            fill_q   <= '0;
            rd_ptr_q <= '0;
        end else begin
            state_q <= state_d;
            fill_q  <= fill_d;
            if (pop)
                rd_ptr_q <= (rd_ptr_q == LAST_PTR) ? '0 : rd_ptr_q + 1'b1;
        end
    end

    assign slot_sum = (CNT_W + 1)'(rd_ptr_q) + (CNT_W + 1)'(fill_q);
    assign wr_slot  = (slot_sum >= DEPTH_X) ? PTR_W'(slot_sum - DEPTH_X)
                                            : PTR_W'(slot_sum);

    for (genvar i = 0; i < DEPTH; i++) begin : g_slot
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                mem[i] <= '0;
            else if (push && (wr_slot == PTR_W'(i)))
                mem[i] <= push_data;
        end
    end

    assign head_data = mem[rd_ptr_q];
    assign fill      = fill_q;
endmodule

// File: rtl/mu_irq_ctrl.sv
module mu_irq_ctrl (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       ien_we,
    input  logic [1:0] ien_wdata,
    input  logic       rx_nonempty,
    output logic [1:0] ien,
    output logic [1:0] pending,
    output logic       irq
);
    logic [1:0] ien_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ien_q <= 2'b00;
        else if (ien_we)
            ien_q <= ien_wdata;
    end

    always_comb begin
        pending    = 2'b00;
        pending[0] = ien_q[0] && rx_nonempty;
        pending[1] = ien_q[1];
    end

    assign irq = |pending;
    assign ien = ien_q;
endmodule

// File: rtl/mu_reg_decode.sv
module mu_reg_decode
    import mu_pkg::*;
#(
    parameter int CNT_W = 4
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [7:0]        bus_addr,
    input  logic              flush_bit,
    input  logic [1:0]        ien,
    input  logic              irq,
    input  logic              rx_nonempty,
    input  logic [CNT_W-1:0]  fill,
    input  logic [BYTE_W-1:0] head_data,
    output logic              data_wr_stb,
    output logic              data_rd_stb,
    output logic              ien_wr_stb,
    output logic              flush_stb,
    output logic [31:0]       bus_rdata
);
    logic rd_acc, wr_acc;

    assign rd_acc = bus_sel && !bus_wr;
    assign wr_acc = bus_sel && bus_wr;

    assign data_wr_stb = wr_acc && (bus_addr == OFS_DATA);
    assign data_rd_stb = rd_acc && (bus_addr == OFS_DATA);
    assign ien_wr_stb  = wr_acc && (bus_addr == OFS_IEN);
    assign flush_stb   = wr_acc && (bus_addr == OFS_IID) && flush_bit;

    always_comb begin
        bus_rdata = 32'h0;
        if (rd_acc) begin
            case (bus_addr)
                OFS_IRQFLAG: bus_rdata = {31'h0, irq};
                OFS_ENABLES: bus_rdata = 32'h1;
                OFS_DATA:    bus_rdata = {24'h0, head_data};
                OFS_IEN:     bus_rdata = {24'h0, 6'b110000, ien};
                OFS_IID:     bus_rdata = {24'h0, 5'b11000, rx_nonempty, !rx_nonempty, !irq};
                OFS_LSTAT:   bus_rdata = {24'h0, 8'h60 | {7'h0, rx_nonempty}};
                OFS_CTRL:    bus_rdata = 32'h3;
                OFS_XSTAT: begin
                    bus_rdata = 32'h0000_030E;
                    if (rx_nonempty)
                        bus_rdata = bus_rdata | 32'h1 | (32'(fill) << 16);
                end
                default:     bus_rdata = 32'h0;
            endcase
        end
    end
endmodule

// File: rtl/mu_regfront.sv
module mu_regfront
    import mu_pkg::*;
#(
    parameter int DEPTH = 8
) (
    input  logic        clk,
    input  logic        rst_n,
    input  logic        bus_sel,
    input  logic        bus_wr,
    input  logic [7:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic        rx_valid,
    input  logic [7:0]  rx_data,
    output logic        rx_ready,
    output logic        tx_valid,
    output logic [7:0]  tx_data,
    output logic        irq
);
    localparam int CNT_W = $clog2(DEPTH + 1);
    localparam int PTR_W = (DEPTH > 1) ? $clog2(DEPTH) : 1;

    logic              data_wr_stb, data_rd_stb, ien_wr_stb, flush_stb;
    logic [1:0]        ien_q;
    logic [1:0]        pend_vec;
    logic              rx_nonempty, rx_full;
    logic [CNT_W-1:0]  fill_cnt;
    logic [BYTE_W-1:0] head_data;
    logic              push;
    logic              wdata_unused;

    assign wdata_unused = ^bus_wdata[31:8];

    assign rx_ready = !rx_full && !flush_stb;
    assign push     = rx_valid && rx_ready;

    mu_reg_decode #(.CNT_W(CNT_W)) u_decode (
        .bus_sel     (bus_sel),
        .bus_wr      (bus_wr),
        .bus_addr    (bus_addr),
        .flush_bit   (bus_wdata[1]),
        .ien         (ien_q),
        .irq         (irq),
        .rx_nonempty (rx_nonempty),
        .fill        (fill_cnt),
        .head_data   (head_data),
        .data_wr_stb (data_wr_stb),
        .data_rd_stb (data_rd_stb),
        .ien_wr_stb  (ien_wr_stb),
        .flush_stb   (flush_stb),
        .bus_rdata   (bus_rdata)
    );

    mu_rx_fifo #(.DEPTH(DEPTH), .CNT_W(CNT_W), .PTR_W(PTR_W)) u_fifo (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (rx_data),
        .pop_req   (data_rd_stb),
        .flush     (flush_stb),
        .head_data (head_data),
        .fill      (fill_cnt),
        .nonempty  (rx_nonempty),
        .full      (rx_full)
    );

    mu_irq_ctrl u_irq (
        .clk         (clk),
        .rst_n       (rst_n),
        .ien_we      (ien_wr_stb),
        .ien_wdata   (bus_wdata[1:0]),
        .rx_nonempty (rx_nonempty),
        .ien         (ien_q),
        .pending     (pend_vec),
        .irq         (irq)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tx_valid <= 1'b0;
            tx_data  <= '0;
        end else begin
            tx_valid <= data_wr_stb;
            if (data_wr_stb)
                tx_data <= bus_wdata[7:0];
        end
    end
endmodule

// File: rtl/mu_regfront_chk.sv
module mu_regfront_chk #(
    parameter int DEPTH = 8,
    parameter int CNT_W = 4
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bus_sel,
    input logic             bus_wr,
    input logic [7:0]       bus_addr,
    input logic [31:0]      bus_wdata,
    input logic             rx_valid,
    input logic             rx_ready,
    input logic             tx_valid,
    input logic [7:0]       tx_data,
    input logic             irq,
    input logic [1:0]       ien,
    input logic [CNT_W-1:0] fill
);
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(DEPTH);

    logic wd_unused;
    logic dwr, drd, flw, acc;

    assign wd_unused = ^bus_wdata[31:8];
    assign dwr = bus_sel && bus_wr && (bus_addr == 8'h40);
    assign drd = bus_sel && !bus_wr && (bus_addr == 8'h40);
    assign flw = bus_sel && bus_wr && (bus_addr == 8'h48) && bus_wdata[1];
    assign acc = rx_valid && rx_ready;

    // R11
    full_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (fill == DEPTH_C) |-> !rx_ready);

    // R11
    fill_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        acc |=> (fill <= DEPTH_C));

    // R12
    tx_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        dwr |=> (tx_valid && tx_data == $past(bus_wdata[7:0])));

    // R12
    tx_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !dwr |=> !tx_valid);

    // R6
    flush_chk: assert property (@(posedge clk) disable iff (!rst_n)
        flw |=> (fill == '0));

    // R8
    empty_read_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drd && fill == '0 && !acc) |=> (fill == '0));

    // R7
    pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drd && fill != '0 && !acc) |=> (fill == CNT_W'($past(fill) - 1'b1)));

    // R4
    irq_tx_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ien[1] |-> irq);

    // R4
    irq_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ien == 2'b00) |-> !irq);
endmodule

bind mu_regfront mu_regfront_chk #(.DEPTH(DEPTH), .CNT_W(CNT_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_sel   (bus_sel),
    .bus_wr    (bus_wr),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rx_valid  (rx_valid),
    .rx_ready  (rx_ready),
    .tx_valid  (tx_valid),
    .tx_data   (tx_data),
    .irq       (irq),
    .ien       (ien_q),
    .fill      (fill_cnt)
);

// File: tb/tb_mu_regfront.sv
module tb_mu_regfront;
    localparam int DEPTH = 8;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [7:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        rx_valid = 1'b0;
    logic [7:0]  rx_data = '0;
    logic        rx_ready, tx_valid, irq;
    logic [7:0]  tx_data;

    int vectors = 0;
    int miscompares = 0;

    // behavioural reference state
    logic [7:0] m_mem [DEPTH];
    int         m_rd = 0;
    int         m_cnt = 0;
    logic [1:0] m_ien = 2'b00;
    logic       m_txv = 1'b0;
    logic [7:0] m_txd = 8'h00;

    always #2.5 clk = ~clk;

    mu_regfront #(.DEPTH(DEPTH)) dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .rx_valid(rx_valid), .rx_data(rx_data), .rx_ready(rx_ready),
        .tx_valid(tx_valid), .tx_data(tx_data), .irq(irq)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic m_irq();
        return m_ien[1] || (m_ien[0] && m_cnt != 0);
    endfunction

    function automatic logic [31:0] m_read(input logic [7:0] a);
        case (a)
            8'h00: return {31'h0, m_irq()};
            8'h04: return 32'h1;
            8'h40: return {24'h0, m_mem[m_rd]};
            8'h44: return 32'hC0 | {30'h0, m_ien};
            8'h48: return 32'hC0 | ((m_cnt != 0) ? 32'h4 : 32'h2) | (m_irq() ? 32'h0 : 32'h1);
            8'h54: return 32'h60 | ((m_cnt != 0) ? 32'h1 : 32'h0);
            8'h60: return 32'h3;
            8'h64: return (m_cnt != 0) ? (32'h30F | (32'(m_cnt) << 16)) : 32'h30E;
            default: return 32'h0;
        endcase
    endfunction

    function automatic string tag_of(input logic [7:0] a);
        case (a)
            8'h00: return "R4";
            8'h40: return (m_cnt != 0) ? "R7" : "R8";
            8'h44: return "R3";
            8'h48: return "R5";
            8'h54: return "R9";
            8'h64: return "R10";
            default: return "R2";
        endcase
    endfunction

    // one clock: drive at falling edge, compare 1 ns later, advance model
    task automatic cyc(input logic s, input logic w, input logic [7:0] a,
                       input logic [31:0] d, input logic rv, input logic [7:0] rb,
                       input string tag);
        logic flush, ready, pop, push;
        int   slot;
        @(negedge clk);
        bus_sel = s; bus_wr = w; bus_addr = a; bus_wdata = d;
        rx_valid = rv; rx_data = rb;
        #1;
        flush = s && w && a == 8'h48 && d[1];
        ready = (m_cnt < DEPTH) && !flush;
        chk("R11", {31'h0, rx_ready}, {31'h0, ready});
        chk("R4", {31'h0, irq}, {31'h0, m_irq()});
        chk("R12", {31'h0, tx_valid}, {31'h0, m_txv});
        if (m_txv) chk("R12", {24'h0, tx_data}, {24'h0, m_txd});
        if (s && !w) chk((tag == "") ? tag_of(a) : tag, bus_rdata, m_read(a));
        pop  = s && !w && a == 8'h40 && m_cnt > 0;
        push = rv && ready;
        slot = (m_rd + m_cnt) % DEPTH;
        m_txv = s && w && a == 8'h40;
        if (m_txv) m_txd = d[7:0];
        if (s && w && a == 8'h44) m_ien = d[1:0];
        if (pop) begin m_rd = (m_rd + 1) % DEPTH; m_cnt--; end
        if (push) begin m_mem[slot] = rb; m_cnt++; end
        if (flush) m_cnt = 0;
    endtask

    task automatic rd(input logic [7:0] a, input string tag);
        cyc(1'b1, 1'b0, a, 32'h0, 1'b0, 8'h00, tag);
    endtask
    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        cyc(1'b1, 1'b1, a, d, 1'b0, 8'h00, "");
    endtask
    task automatic rx(input logic [7:0] b);
        cyc(1'b0, 1'b0, 8'h00, 32'h0, 1'b1, b, "");
    endtask
    task automatic idle();
        cyc(1'b0, 1'b0, 8'h00, 32'h0, 1'b0, 8'h00, "");
    endtask

    initial begin
        #(200000 * 5);
        miscompares++;
        $display("FAIL R1 watchdog actual=running expected=finished");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        for (int i = 0; i < DEPTH; i++) m_mem[i] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1: reset state seen through the ports
        rd(8'h44, "R1");
        rd(8'h64, "R1");
        rd(8'h40, "R1");
        // R2: fixed and unmapped offsets, write to unmapped ignored
        rd(8'h04, "");
        rd(8'h60, "");
        rd(8'h4C, "");
        wr(8'h5C, 32'hFFFF_FFFF);
        rd(8'h5C, "R2");
        rd(8'h48, "R2");
        // R3/R4: enable register
        wr(8'h44, 32'hFF);
        rd(8'h44, "");
        rd(8'h00, "");
        rd(8'h48, "");
        wr(8'h44, 32'h0);
        rd(8'h00, "R4");
        rd(8'h48, "R5");
        // R11: receive three bytes
        rx(8'h11); rx(8'h22); rx(8'h33);
        rd(8'h54, "R9");
        rd(8'h64, "R10");
        rd(8'h48, "R5");
        wr(8'h44, 32'h1);
        rd(8'h00, "R4");
        rd(8'h48, "R5");
        // R7: pops in order
        rd(8'h40, "R7"); rd(8'h40, "R7"); rd(8'h40, "R7");
        rd(8'h00, "R4");
        // R8: empty read returns stale slot, no state change
        rd(8'h40, "R8");
        rd(8'h64, "R8");
        // R11: fill past depth with wrap, extra bytes dropped
        for (int i = 0; i < 10; i++) rx(8'hA0 + 8'(i));
        rd(8'h64, "R11");
        rd(8'h54, "R9");
        // R7: drain across the wrap, with a concurrent push
        rd(8'h40, "R7");
        cyc(1'b1, 1'b0, 8'h40, 32'h0, 1'b1, 8'h5A, "R7");
        for (int i = 0; i < 7; i++) rd(8'h40, "R7");
        rd(8'h64, "R10");
        // R6: flush blocks the same-cycle byte and empties the queue
        rx(8'hC1); rx(8'hC2);
        wr(8'h48, 32'h1);
        rd(8'h64, "R6");
        cyc(1'b1, 1'b1, 8'h48, 32'h2, 1'b1, 8'hEE, "");
        rd(8'h64, "R6");
        rd(8'h54, "R6");
        // R12: transmit strobe
        wr(8'h40, 32'h0000_01A5);
        idle();
        wr(8'h40, 32'h3C);
        wr(8'h40, 32'hC3);
        idle();
        idle();
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule